// File: doc/BRIEF.md
# Oscillator Settling Wait Counter

This block measures how long an external crystal oscillator has been running after it was switched on or after the chip left a low-power stop state. It counts edges of the oscillator clock and exposes the elapsed time as an 8-bit read-only status byte. The byte fills like a thermometer, from the most significant bit downward, as the count passes eight fixed power-of-two thresholds. A 3-bit wait select picks which threshold ends the wait. When the count reaches that threshold, counting halts and a ready flag rises.

Three conditions clear the count, the status byte and the ready flag: the asynchronous reset, a stop-mode request held high, and an oscillator-off control held high. Counting restarts from zero on the first oscillator edge after the last clear condition drops. The status byte is read through a small request/response port. The port returns either the whole byte or one selected bit. The port has no back-pressure: every request is accepted, and its response appears as a one-cycle valid pulse on the next edge. The port has no write path, so nothing outside the block can alter the status byte.

Top module: `osc_settle_counter`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `ready` and `rd_valid` are 0 and a byte read returns 8'h00.
- R2: With threshold exponents E = {8,9,10,11,13,15,17,18} for index i = 0..7, status bit 7-i becomes 1 on the clock edge on which the number of counted edges since the last clear equals 2^E[i]. Bit 7 sets first and bit 0 sets last.
- R3: A status bit that is 1 stays 1 until a clear condition occurs.
- R4: While `stop_req` is 1, each edge forces the count, the status byte and `ready` to zero. Counting restarts from zero on the first edge after `stop_req` returns to 0.
- R5: `osc_off` at 1 clears and restarts the block in the same way as `stop_req`.
- R6: `wait_sel` code c (0..7) picks threshold index c. Counting stops at 2^E[c] edges, so status bits below bit 7-c stay 0. If `wait_sel` is lowered below a count already reached, counting stops at the count held and the bits already set remain set.
- R7: The count saturates at the selected threshold and never wraps. Holding past the threshold changes neither the status byte nor `ready`.
- R8: `ready` rises on the same edge that sets status bit 7-c for the selected code c, or on the edge after `wait_sel` is lowered below a count already reached. It then stays 1 until a clear condition occurs.
- R9: A read request `rd_req` is sampled on an edge. On the following cycle `rd_valid` is 1 for one cycle, and `rd_data` carries the status byte held before that edge. With `rd_byte`=1, `rd_data` is the whole byte. With `rd_byte`=0, `rd_data` is {7'b0, status[`rd_sel`]}.
- R10: The status byte is always a run of ones starting at bit 7 followed by zeros (00, 80, C0, ... FF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock being counted |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop-mode request; holds the block cleared while 1 |
| osc_off | input | 1 | Oscillator-off control; holds the block cleared while 1 |
| wait_sel | input | 3 | Selected wait threshold index |
| rd_req | input | 1 | Read request, sampled on each edge |
| rd_byte | input | 1 | 1 = whole byte read, 0 = single-bit read |
| rd_sel | input | 3 | Bit position for a single-bit read |
| rd_valid | output | 1 | Read response valid, one cycle per request |
| rd_data | output | 8 | Read response data |
| ready | output | 1 | Selected wait time has elapsed |

## Verification
The assertions check the following on every cycle: the status byte keeps its thermometer shape, set bits never drop without a clear, a clear empties both the status byte and `ready`, a count held at or past its limit never moves, `ready` rises only when the selected bit is set, and each read request yields exactly one valid pulse. Only the bench scenarios can show that each threshold is reached on exactly the right edge count for every select code. The same holds for counting restarting from zero after each kind of clear, lowering the select mid-count, and single-bit reads returning the right position.

// File: rtl/osc_settle_pkg.sv
`timescale 1ns/1ps
package osc_settle_pkg;
  localparam int unsigned SLOTS = 8;
  localparam int unsigned SEL_W = $clog2(SLOTS);
  localparam int unsigned DEFAULT_EXP [SLOTS] = '{8, 9, 10, 11, 13, 15, 17, 18};

  typedef logic [SLOTS-1:0] settle_status_t;

  function automatic logic is_msb_thermo(input settle_status_t s);
    logic [SLOTS:0] inv_p1;
    inv_p1 = {1'b0, ~s} + {{SLOTS{1'b0}}, 1'b1};
    return $onehot0(inv_p1);
  endfunction
endpackage

// File: rtl/settle_tick_counter.sv
`timescale 1ns/1ps
module settle_tick_counter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (clr)
      cnt_nxt = '0;
    else if (cnt_q < limit)
      cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R7: a count that has reached its limit holds unless cleared
  assert_no_wrap_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (cnt_q >= limit && !clr) |=> (cnt_q == $past(cnt_q)));

  // R4/R5: a clear zeroes the count
  assert_count_clear_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/settle_threshold_bank.sv
`timescale 1ns/1ps
module settle_threshold_bank
  import osc_settle_pkg::*;
#(
  parameter int unsigned STEP_EXP [SLOTS] = DEFAULT_EXP,
  parameter int unsigned CNT_W = STEP_EXP[SLOTS-1] + 1
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt_nxt,
  output settle_status_t   status
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic [CNT_W-1:0] THR = ONE << STEP_EXP[g];
    localparam int unsigned BITPOS = SLOTS - 1 - g;

    always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n)               status[BITPOS] <= 1'b0;
      else if (clr)             status[BITPOS] <= 1'b0;
      else if (cnt_nxt >= THR)  status[BITPOS] <= 1'b1;
    end

    // R3: a set bit stays set without a clear
    assert_sticky_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (status[BITPOS] && !clr) |=> status[BITPOS]);
  end

  // R10: status keeps its MSB-first thermometer shape
  assert_thermo_R10: assert property (@(posedge clk_osc) disable iff (!rst_n)
    is_msb_thermo(status));
endmodule

// File: rtl/settle_read_port.sv
`timescale 1ns/1ps
module settle_read_port
  import osc_settle_pkg::*;
(
  input  logic             clk_osc,
  input  logic             rst_n,
  input  settle_status_t   status,
  input  logic             rd_req,
  input  logic             rd_byte,
  input  logic [SEL_W-1:0] rd_sel,
  output logic             rd_valid,
  output logic [SLOTS-1:0] rd_data
);
  logic [SLOTS-1:0] rd_mux;

  always_comb begin
    if (rd_byte) rd_mux = status;
    else         rd_mux = {{(SLOTS-1){1'b0}}, status[rd_sel]};
  end

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end

  // R9: one response pulse per request, none otherwise
  assert_rd_resp_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    rd_req |=> rd_valid);
  assert_rd_quiet_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
endmodule

// File: rtl/osc_settle_counter.sv
`timescale 1ns/1ps
module osc_settle_counter
  import osc_settle_pkg::*;
#(
  parameter int unsigned STEP_EXP [SLOTS] = DEFAULT_EXP
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             osc_off,
  input  logic [2:0]       wait_sel,
  input  logic             rd_req,
  input  logic             rd_byte,
  input  logic [2:0]       rd_sel,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             ready
);
  localparam int unsigned CNT_W = STEP_EXP[SLOTS-1] + 1;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             clr;
  logic [CNT_W-1:0] thr_tbl [SLOTS];
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_nxt;
  settle_status_t   status;

  assign clr = stop_req | osc_off;

  for (genvar g = 0; g < SLOTS; g++) begin : g_thr
    assign thr_tbl[g] = ONE << STEP_EXP[g];
  end

  assign limit = thr_tbl[wait_sel];

  settle_tick_counter #(.CNT_W(CNT_W)) u_count (
    .clk_osc (clk_osc),
    .rst_n   (rst_n),
    .clr     (clr),
    .limit   (limit),
    .cnt_nxt (cnt_nxt)
  );

  settle_threshold_bank #(.STEP_EXP(STEP_EXP), .CNT_W(CNT_W)) u_bank (
    .clk_osc (clk_osc),
    .rst_n   (rst_n),
    .clr     (clr),
    .cnt_nxt (cnt_nxt),
    .status  (status)
  );

  settle_read_port u_read (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .status   (status),
    .rd_req   (rd_req),
    .rd_byte  (rd_byte),
    .rd_sel   (rd_sel),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)                  ready <= 1'b0;
    else if (clr)                ready <= 1'b0;
    else if (cnt_nxt >= limit)   ready <= 1'b1;
  end

  // R4/R5: a clear empties status and drops ready
  assert_clear_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    clr |=> (status == '0 && !ready));

  // R8: ready rises only with the selected bit set
  assert_ready_bit_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(ready) |-> status[3'd7 - $past(wait_sel)]);

  // R8: ready holds without a clear
  assert_ready_sticky_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (ready && !clr) |=> ready);
endmodule

// File: tb/osc_settle_counter_test.sv
`timescale 1ns/1ps
module osc_settle_counter_test;
  localparam int unsigned TB_EXP [8] = '{2, 3, 4, 5, 7, 9, 11, 12};
  // vector: {sel[7:0], expected status[7:0], expected cycles[15:0]}
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'h80, 16'd4},    {8'd1, 8'hC0, 16'd8},
    {8'd2, 8'hE0, 16'd16},   {8'd3, 8'hF0, 16'd32},
    {8'd4, 8'hF8, 16'd128},  {8'd5, 8'hFC, 16'd512},
    {8'd6, 8'hFE, 16'd2048}, {8'd7, 8'hFF, 16'd4096}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b1, osc_off = 1'b0;
  logic [2:0] wait_sel = 3'd0;
  logic rd_req = 1'b0, rd_byte = 1'b1;
  logic [2:0] rd_sel = 3'd0;
  logic rd_valid, ready;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  osc_settle_counter #(.STEP_EXP(TB_EXP)) uut (
    .clk_osc(clk), .rst_n(rst_n), .stop_req(stop_req), .osc_off(osc_off),
    .wait_sel(wait_sel), .rd_req(rd_req), .rd_byte(rd_byte), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_byte(output logic [7:0] d, output logic v);
    rd_byte = 1'b1; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic read_bit(input logic [2:0] pos, output logic [7:0] d);
    rd_byte = 1'b0; rd_sel = pos; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; rd_byte = 1'b1;
    d = rd_data;
  endtask

  task automatic clear_with_stop(input logic [2:0] sel);
    wait_sel = sel; stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic count_to_ready(output int n);
    n = 0;
    while (!ready && n < 10000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    int n;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(ready == 1'b0 && rd_valid == 1'b0, "R1 in reset", {ready, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_byte(d, v);
    check(v == 1'b1 && d == 8'h00, "R1 status after reset", d, 0);
    check(ready == 1'b0, "R1 ready after reset", ready, 0);

    // R2 R6 R8: table of select codes
    for (int k = 0; k < 8; k++) begin
      clear_with_stop(VEC[k][26:24]);
      count_to_ready(n);
      check(n == int'(VEC[k][15:0]), "R8 R2 cycles to ready", n, VEC[k][15:0]);
      read_byte(d, v);
      check(d == VEC[k][23:16], "R6 R10 status at limit", d, VEC[k][23:16]);
      repeat (40) @(negedge clk);
      read_byte(d, v);
      check(d == VEC[k][23:16] && ready, "R7 R3 held past limit", {ready, d}, {1'b1, VEC[k][23:16]});
    end

    // R9: single-bit reads with status F0
    clear_with_stop(3'd3);
    count_to_ready(n);
    read_bit(3'd7, d); check(d == 8'h01, "R9 bit7", d, 1);
    read_bit(3'd4, d); check(d == 8'h01, "R9 bit4", d, 1);
    read_bit(3'd3, d); check(d == 8'h00, "R9 bit3", d, 0);
    read_bit(3'd0, d); check(d == 8'h00, "R9 bit0", d, 0);

    // R2: exact edge of first threshold (4 edges), read pipelined
    clear_with_stop(3'd7);
    repeat (3) @(negedge clk);
    rd_byte = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    check(rd_data == 8'h00, "R2 before threshold", rd_data, 0);
    @(negedge clk); rd_req = 1'b0;
    check(rd_data == 8'h80, "R2 at threshold", rd_data, 8'h80);

    // R6 R8: lower select below count already reached (count 20, status E0)
    clear_with_stop(3'd7);
    repeat (20) @(negedge clk);
    check(ready == 1'b0, "R8 not ready mid-count", ready, 0);
    wait_sel = 3'd0;
    @(negedge clk);
    check(ready == 1'b1, "R8 ready after select lowered", ready, 1);
    read_byte(d, v);
    check(d == 8'hE0, "R6 status kept after select lowered", d, 8'hE0);

    // R5: oscillator off clears, then restart from zero
    clear_with_stop(3'd7);
    repeat (100) @(negedge clk);
    osc_off = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R5 ready cleared", ready, 0);
    read_byte(d, v);
    check(d == 8'h00, "R5 status cleared", d, 0);
    osc_off = 1'b0;
    count_to_ready(n);
    check(n == 4096, "R5 restart from zero", n, 4096);

    // R4: stop request clears a saturated block
    clear_with_stop(3'd2);
    count_to_ready(n);
    stop_req = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R4 ready cleared by stop", ready, 0);
    read_byte(d, v);
    check(d == 8'h00, "R4 status cleared by stop", d, 0);
    stop_req = 1'b0;
    count_to_ready(n);
    check(n == 16, "R4 restart after stop", n, 16);

    // R1: reset in mid-count
    clear_with_stop(3'd7);
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ready == 1'b0 && rd_data == 8'h00, "R1 async reset", {ready, rd_data}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    read_byte(d, v);
    check(d == 8'h00, "R1 status after second reset", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule